// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits beside the transmit and receive FIFOs of an SPI master and turns their fill levels, the shifter's busy indication and the receive-push strobe into eight status flags. Six of the flags follow the FIFO levels directly. Two of them are sticky: receive overflow and transfer complete. Software reads the flags through a status register and clears the sticky ones by writing ones to their positions. A driver can therefore write back the value it just read.

An 8-bit interrupt-enable register uses the same bit positions as the status register. The unit ANDs the flags with the enables, ORs the result and registers it once to drive a single interrupt line. A threshold register holds two 6-bit FIFO watermarks that set the transmit and receive data-request flags. The register interface is a simple select/write/read port with combinational read data.

Top module: `spi_stat_irq_unit`

## Requirements
- R1: Status bit 0 (transmit empty) is 1 exactly when the transmit level is 0. Status bit 2 (transmit full) is 1 exactly when the transmit level equals the FIFO depth (64).
- R2: Status bit 1 (transmit request) is 1 while the transmit level is less than or equal to the transmit threshold, which is threshold-register bits 5:0.
- R3: Status bit 3 (receive ready) is 1 while the receive level is at least 1. Status bit 5 (receive full) is 1 exactly when the receive level equals the depth.
- R4: Status bit 4 (receive request) is 1 while the receive level is strictly greater than the receive threshold, which is threshold-register bits 21:16.
- R5: Status bit 6 (receive overflow) becomes 1 after a clock edge at which a receive push occurs while the receive level equals the depth. It then stays 1 until it is cleared. A push at any lower level does not set it.
- R6: Status bit 7 (transfer complete) becomes 1 after the first clock edge at which the condition "transmit level 0 and shifter idle" holds, provided that the condition was false at the previous edge. It then stays 1 until it is cleared.
- R7: Writing the status register clears bit 6 and/or bit 7 wherever the written data has a 1. A 0 leaves the bit unchanged. The live bits are not affected by the write. A set event in the same cycle as a clear takes priority over the clear.
- R8: The enable register (bits 7:0) uses the status bit positions. The interrupt output equals the OR of (status AND enable) as sampled at the previous clock edge, so it lags by one cycle.
- R9: After reset, the enable register reads 0, both thresholds read 0, both sticky bits are 0 and the interrupt output is 0.
- R10: The register select works as follows: 0 reads or writes the status, 1 the enable register and 2 the threshold register. Select 3 reads zero and a write to it has no effect. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level_i | input | 7 | Transmit FIFO word count (0..64) |
| rx_level_i | input | 7 | Receive FIFO word count (0..64) |
| shift_busy_i | input | 1 | Shift register holds a word in flight |
| rx_push_i | input | 1 | A received word is written into the receive FIFO this cycle |
| reg_sel_i | input | 2 | Register select: 0 status, 1 enable, 2 threshold |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle: the one-cycle interrupt latency against status and enable, the priority of a set event over a write-one-to-clear, the clearing of sticky bits and the capture of threshold writes. The comparison of the level flags against the thresholds can only be shown by the bench. It sweeps every FIFO level from 0 to the depth for several threshold pairs, including thresholds 0 and 63. The bench scenarios also show the edge-triggered nature of transfer complete, the exact full-level condition for overflow, and the selectivity of clear-by-write.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned FLAG_N    = 8;
  localparam int unsigned STICKY_N  = 2;
  localparam int unsigned RX_THR_LSB = 16;

  // Status bit positions; software decodes these.
  localparam int unsigned B_TXEMP  = 0;
  localparam int unsigned B_TXREQ  = 1;
  localparam int unsigned B_TXFUL  = 2;
  localparam int unsigned B_RXRDY  = 3;
  localparam int unsigned B_RXREQ  = 4;
  localparam int unsigned B_RXFUL  = 5;
  localparam int unsigned B_RXOVF  = 6;
  localparam int unsigned B_XDONE  = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef logic [FLAG_N-1:0] flags_t;
endpackage

// File: rtl/spi_level_flags.sv
module spi_level_flags
  import spi_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned THR_W = 6,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             shift_busy_i,
  input  logic             rx_push_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  output logic [5:0]       live_o,
  output logic             ovf_evt_o,
  output logic             done_evt_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic idle_now;
  logic idle_prev_q;
  logic idle_prev_d;
  logic rx_full;

  always_comb begin
    rx_full              = (rx_level_i == FULL_LVL);
    live_o               = '0;
    live_o[B_TXEMP]      = (tx_level_i == '0);
    live_o[B_TXREQ]      = (tx_level_i <= LVL_W'(tx_thr_i));
    live_o[B_TXFUL]      = (tx_level_i == FULL_LVL);
    live_o[B_RXRDY]      = (rx_level_i != '0);
    live_o[B_RXREQ]      = (rx_level_i > LVL_W'(rx_thr_i));
    live_o[B_RXFUL]      = rx_full;
    idle_now             = (tx_level_i == '0) && !shift_busy_i;
    idle_prev_d          = idle_now;
    ovf_evt_o            = rx_push_i && rx_full;
    done_evt_o           = idle_now && !idle_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_prev_q <= 1'b1;
    else        idle_prev_q <= idle_prev_d;
  end
endmodule

// File: rtl/spi_sticky_bank.sv
module spi_sticky_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    logic d;
    logic en;

    always_comb begin
      en = set_i[g] || clr_i[g];
      d  = set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end

    assign q_o[g] = q;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q_o[g]);
    // R7
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);
  end
endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
  import spi_stat_pkg::*;
#(
  parameter int unsigned THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  flags_t           status_i,
  output flags_t           ien_o,
  output logic [THR_W-1:0] tx_thr_o,
  output logic [THR_W-1:0] rx_thr_o,
  output logic [REG_W-1:0] rdata_o
);
  flags_t           ien_q,  ien_d;
  logic [THR_W-1:0] txt_q,  txt_d;
  logic [THR_W-1:0] rxt_q,  rxt_d;
  logic             ien_we, thr_we;

  always_comb begin
    ien_we = reg_wr_i && (reg_sel_i == SEL_IEN);
    thr_we = reg_wr_i && (reg_sel_i == SEL_THR);
    ien_d  = reg_wdata_i[FLAG_N-1:0];
    txt_d  = reg_wdata_i[THR_W-1:0];
    rxt_d  = reg_wdata_i[RX_THR_LSB +: THR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      txt_q <= '0;
      rxt_q <= '0;
    end else begin
      if (ien_we) ien_q <= ien_d;
      if (thr_we) begin
        txt_q <= txt_d;
        rxt_q <= rxt_d;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_i)
      SEL_STAT: rdata_o[FLAG_N-1:0] = status_i;
      SEL_IEN:  rdata_o[FLAG_N-1:0] = ien_q;
      SEL_THR: begin
        rdata_o[THR_W-1:0]              = txt_q;
        rdata_o[RX_THR_LSB +: THR_W]    = rxt_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign ien_o    = ien_q;
  assign tx_thr_o = txt_q;
  assign rx_thr_o = rxt_q;

  // R10
  thr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i == SEL_THR) |=>
      (tx_thr_o == $past(reg_wdata_i[THR_W-1:0])) &&
      (rx_thr_o == $past(reg_wdata_i[RX_THR_LSB +: THR_W])));
endmodule

// File: rtl/spi_stat_irq_unit.sv
module spi_stat_irq_unit
  import spi_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned THR_W = 6,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             shift_busy_i,
  input  logic             rx_push_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic [5:0]          live;
  logic                ovf_evt, done_evt;
  logic [STICKY_N-1:0] stk_set, stk_clr, stk_q;
  logic [THR_W-1:0]    tx_thr, rx_thr;
  flags_t              status, ien;
  logic                stat_we;
  logic                irq_d, irq_q;

  spi_level_flags #(.DEPTH(DEPTH), .THR_W(THR_W)) u_lvl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_level_i   (tx_level_i),
    .rx_level_i   (rx_level_i),
    .shift_busy_i (shift_busy_i),
    .rx_push_i    (rx_push_i),
    .tx_thr_i     (tx_thr),
    .rx_thr_i     (rx_thr),
    .live_o       (live),
    .ovf_evt_o    (ovf_evt),
    .done_evt_o   (done_evt)
  );

  always_comb begin
    stat_we    = reg_wr_i && (reg_sel_i == SEL_STAT);
    stk_set    = {done_evt, ovf_evt};
    stk_clr    = stat_we ? reg_wdata_i[B_XDONE:B_RXOVF] : '0;
    status     = {stk_q, live};
  end

  spi_sticky_bank #(.N(STICKY_N)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (stk_set),
    .clr_i (stk_clr),
    .q_o   (stk_q)
  );

  spi_stat_regs #(.THR_W(THR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel_i   (reg_sel_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_i    (status),
    .ien_o       (ien),
    .tx_thr_o    (tx_thr),
    .rx_thr_o    (rx_thr),
    .rdata_o     (reg_rdata_o)
  );

  always_comb irq_d = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R8
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status & ien))));
  // R6
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> status[B_XDONE]);
endmodule

// File: tb/tb_spi_stat_irq_unit.sv
`timescale 1ns/1ps
module tb_spi_stat_irq_unit;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  tx_level, rx_level;
  logic        busy, push;
  logic [1:0]  sel;
  logic        wr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int vecs = 0;
  int bad  = 0;

  always #4 clk = ~clk;

  spi_stat_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .shift_busy_i(busy), .rx_push_i(push), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; sel = 2'd0;
  endtask

  task automatic rreg(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s; #1;
    d = rdata;
  endtask

  function automatic logic [5:0] live_exp(input int t, input int r, input int tt, input int rt);
    logic [5:0] e;
    e[0] = (t == 0);
    e[1] = (t <= tt);
    e[2] = (t == DEPTH);
    e[3] = (r >= 1);
    e[4] = (r > rt);
    e[5] = (r == DEPTH);
    return e;
  endfunction

  initial begin
    #(8ns * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int thr_set [4] = '{0, 1, 31, 63};
    rst_n = 1'b0; tx_level = 0; rx_level = 0; busy = 0; push = 0;
    sel = 0; wr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset state
    rreg(2'd0, d); chk("R9 status", d, 32'h03);
    rreg(2'd1, d); chk("R9 enable", d, 32'h0);
    rreg(2'd2, d); chk("R9 thresholds", d, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);

    // R10 map: sel 3 reads zero, write ignored; unused bits read zero
    wreg(2'd3, 32'hFFFF_FFFF);
    rreg(2'd3, d); chk("R10 sel3", d, 32'h0);
    rreg(2'd1, d); chk("R10 sel3 no effect enable", d, 32'h0);
    rreg(2'd2, d); chk("R10 sel3 no effect thr", d, 32'h0);
    wreg(2'd2, 32'hFFFF_FFFF);
    rreg(2'd2, d); chk("R10 thr field mask", d, 32'h003F_003F);
    wreg(2'd1, 32'hFFFF_FFFF);
    rreg(2'd1, d); chk("R10 enable mask", d, 32'h0000_00FF);
    wreg(2'd1, 32'h0);

    // R1 R2 R3 R4 sweeps
    @(negedge clk); busy = 1'b1;
    foreach (thr_set[k]) begin
      int tt = thr_set[k];
      int rt = 63 - thr_set[k];
      wreg(2'd2, (rt << 16) | tt);
      for (int lv = 0; lv <= DEPTH; lv++) begin
        logic [5:0] e;
        @(negedge clk);
        tx_level = 7'(lv); rx_level = 7'(DEPTH - lv);
        #1;
        e = live_exp(lv, DEPTH - lv, tt, rt);
        sel = 2'd0; #1;
        chk("R1 R2 R3 R4 live flags", rdata, {24'b0, 2'b00, e});
      end
    end

    // R5 overflow: push at depth-1 does nothing, push at depth sets
    @(negedge clk); rx_level = 7'(DEPTH - 1); push = 1'b1;
    @(negedge clk); push = 1'b0;
    rreg(2'd0, d); chk("R5 no ovf below full", {31'b0, d[6]}, 32'h0);
    @(negedge clk); rx_level = 7'(DEPTH); push = 1'b1;
    @(negedge clk); push = 1'b0; rx_level = 7'd0;
    rreg(2'd0, d); chk("R5 ovf set", {31'b0, d[6]}, 32'h1);
    repeat (3) @(posedge clk);
    rreg(2'd0, d); chk("R5 ovf sticky", {31'b0, d[6]}, 32'h1);

    // R8 irq for overflow with one-cycle lag
    wreg(2'd1, 32'h40);
    chk("R8 irq lag", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R8 irq ovf", {31'b0, irq}, 32'h1);
    wreg(2'd1, 32'h0);

    // R7 clearing bit 7 only leaves overflow; then clear overflow
    wreg(2'd0, 32'h80);
    rreg(2'd0, d); chk("R7 selective clear", {31'b0, d[6]}, 32'h1);
    wreg(2'd0, 32'h3F);
    rreg(2'd0, d); chk("R7 live bits unaffected", {31'b0, d[6]}, 32'h1);
    wreg(2'd0, 32'h40);
    rreg(2'd0, d); chk("R7 ovf cleared", {31'b0, d[6]}, 32'h0);

    // R7 set wins over clear in same cycle
    @(negedge clk); rx_level = 7'(DEPTH); push = 1'b1; sel = 2'd0; wdata = 32'h40; wr = 1'b1;
    @(negedge clk); push = 1'b0; wr = 1'b0; rx_level = 7'd0;
    rreg(2'd0, d); chk("R7 set beats clear", {31'b0, d[6]}, 32'h1);
    wreg(2'd0, 32'h40);

    // R6 transfer complete on idle entry
    @(negedge clk); tx_level = 7'd3; busy = 1'b1;
    @(negedge clk); rreg(2'd0, d); chk("R6 not done busy", {31'b0, d[7]}, 32'h0);
    @(negedge clk); tx_level = 7'd0; busy = 1'b1;
    @(negedge clk); rreg(2'd0, d); chk("R6 not done shifter busy", {31'b0, d[7]}, 32'h0);
    @(negedge clk); busy = 1'b0;
    @(posedge clk); #1;
    sel = 2'd0; #1; chk("R6 done set", {31'b0, rdata[7]}, 32'h1);
    wreg(2'd0, 32'h80);
    rreg(2'd0, d); chk("R6 R7 done cleared and stays clear while idle", {31'b0, d[7]}, 32'h0);

    // R8 each enable bit against live flags in two setups
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        logic [5:0] e;
        @(negedge clk);
        tx_level = (s == 0) ? 7'd0 : 7'(DEPTH);
        rx_level = (s == 0) ? 7'(DEPTH) : 7'd0;
        busy = 1'b1;
        e = live_exp(int'(tx_level), int'(rx_level), 63, 0);
        wreg(2'd1, 32'h0);
        @(posedge clk); #1;
        wreg(2'd1, 32'(1) << i);
        chk("R8 irq before lag", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        chk("R8 irq per enable", {31'b0, irq}, (i < 6) ? {31'b0, e[i]} : 32'h0);
      end
    end
    wreg(2'd1, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule